// File: doc/BRIEF.md
# Programmable Three-by-Three Color Matrix Converter

This block converts one 10-bit three-component pixel per valid cycle through a programmable 3x3 matrix. Each of the three results is the weighted sum of the red/Cr, green/Y and blue/Cb inputs plus a per-result offset. The results come out as G/Y, B/Cb and R/Cr. The nine weights and three offsets are static configuration inputs in sign-and-magnitude form. A bypass mode routes the components straight through. An optional saturation stage keeps results inside the 10-bit code range.

The converter sits between an input formatter and the later stages of a video pipeline. The pipeline depth is the same in both paths, so the sync signals that travel alongside the pixels can be delayed by a fixed amount. The bypass and saturation controls pass through a mode register. That register comes out of reset with bypass on and saturation off.

Top module: `color_matrix_csc`

## Requirements
- R1: Weight `coefMat[o][i]` is 16 bits: bit 15 is the sign, bits 14:10 are the integer magnitude and bits 9:0 the fraction. Its value is ±(bits 14:10 + bits 9:0 / 1024). The sign applies to the whole weight.
- R2: Each result is the sum of the three products, kept at full precision and rounded to the nearest integer, with halves rounded upward, before the offset is added.
- R3: `offsetVec[o]` is 10 bits: bit 9 is the sign and bits 8:0 the magnitude. It is added to the rounded sum of result o.
- R4: Result index o is 0 for G/Y (`outGy`), 1 for B/Cb (`outBcb`) and 2 for R/Cr (`outRcr`). Input index i is 0 for `inR`, 1 for `inG` and 2 for `inB`.
- R5: In bypass mode, `outGy` = `inG`, `outBcb` = `inB` and `outRcr` = `inR`, with no weights or offsets applied.
- R6: With saturation on, a result below 0 gives 0 and a result above 1023 gives 1023.
- R7: With saturation off, the output is the low 10 bits of the two's-complement result.
- R8: A pixel sampled with `inValid` high on a rising edge appears with `outValid` high after the second edge that follows. That is three registers in both paths, and one pixel is accepted every cycle.
- R9: While reset is asserted, `outValid` and all outputs are 0. Outputs hold their values while `outValid` is low, and inputs sampled with `inValid` low have no effect.
- R10: The mode register loads `bypassEn`/`clampEn` on every edge and resets to bypass on, saturation off. A pixel uses the mode held in that register on the edge where the pixel is sampled.
- R11: A sign bit with zero magnitude, in a weight or an offset, acts as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel strobe |
| inR | input | 10 | R/Cr input component |
| inG | input | 10 | G/Y input component |
| inB | input | 10 | B/Cb input component |
| coefMat | input | 3x3x16 | Weights indexed [result][input], sign-magnitude |
| offsetVec | input | 3x10 | Per-result offsets, sign-magnitude |
| bypassEn | input | 1 | Requests pass-through mode |
| clampEn | input | 1 | Requests output saturation |
| outValid | output | 1 | Output pixel strobe |
| outGy | output | 10 | G/Y result |
| outBcb | output | 10 | B/Cb result |
| outRcr | output | 10 | R/Cr result |

## Verification
Two things can happen on the same edge: a change of mode and the sampling of a pixel. The rule is that a pixel takes the mode registered before its own sampling edge. This is provoked by releasing reset with conversion requested and sending one pixel on the very first edge, then another on the next edge. The first must come out untouched and the second converted. Turning saturation off while a stream runs is checked in the same way: only pixels sampled after the mode register updates show wrapped results.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int CSC_DATA_W = 10;
  localparam int CSC_INT_W  = 6;
  localparam int CSC_FRAC_W = 10;
  localparam int CSC_OFS_W  = 10;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic ld1;     // capture products
    logic ld2;     // capture offset sums
    logic ld3;     // capture outputs
    logic byp3;    // stage-3 pixel was sampled in bypass mode
    logic clamp3;  // stage-3 pixel was sampled with saturation
  } cscStrobe_t;

endpackage

// File: rtl/csc_control.sv
module csc_control
  import csc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       bypassEn,
  input  logic       clampEn,
  output cscStrobe_t strobe,
  output logic       outValid
);

  logic modeByp, modeClamp;
  logic v1, v2, v3;
  logic byp1, byp2, clamp1, clamp2;

  // mode register: reloaded every edge, resets to pass-through
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeByp   <= 1'b1;
      modeClamp <= 1'b0;
    end else begin
      modeByp   <= bypassEn;
      modeClamp <= clampEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  // mode travels with the pixel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byp1   <= 1'b1;
      clamp1 <= 1'b0;
      byp2   <= 1'b1;
      clamp2 <= 1'b0;
    end else begin
      if (inValid) begin
        byp1   <= modeByp;
        clamp1 <= modeClamp;
      end
      if (v1) begin
        byp2   <= byp1;
        clamp2 <= clamp1;
      end
    end
  end

  always_comb begin
    strobe.ld1    = inValid;
    strobe.ld2    = v1;
    strobe.ld3    = v2;
    strobe.byp3   = byp2;
    strobe.clamp3 = clamp2;
  end

  assign outValid = v3;

endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int DATA_W = CSC_DATA_W,
  parameter int INT_W  = CSC_INT_W,
  parameter int FRAC_W = CSC_FRAC_W,
  parameter int OFS_W  = CSC_OFS_W
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  cscStrobe_t                             strobe,
  input  logic [DATA_W-1:0]                      inR,
  input  logic [DATA_W-1:0]                      inG,
  input  logic [DATA_W-1:0]                      inB,
  input  logic [2:0][2:0][INT_W+FRAC_W-1:0]      coefMat,
  input  logic [2:0][OFS_W-1:0]                  offsetVec,
  output logic [DATA_W-1:0]                      outGy,
  output logic [DATA_W-1:0]                      outBcb,
  output logic [DATA_W-1:0]                      outRcr
);

  localparam int COEF_W   = INT_W + FRAC_W;
  localparam int MAG_W    = COEF_W - 1;
  localparam int PROD_W   = DATA_W + 1 + COEF_W;
  localparam int SUM_W    = PROD_W + 2;
  localparam int RND_W    = SUM_W - FRAC_W;
  localparam int RES_W    = RND_W + 1;
  localparam int MAX_CODE = (1 << DATA_W) - 1;

  logic [2:0][DATA_W-1:0] pixIn;
  assign pixIn = {inB, inG, inR};

  // stage 1: nine full-precision products
  logic signed [PROD_W-1:0] prodC [3][3];
  logic signed [PROD_W-1:0] prodQ [3][3];
  logic [2:0][DATA_W-1:0]   bypQ1, bypQ2;

  always_comb begin
    for (int o = 0; o < 3; o++) begin
      for (int i = 0; i < 3; i++) begin
        logic [MAG_W-1:0]         coefMag;
        logic signed [COEF_W-1:0] coefVal;
        coefMag = coefMat[o][i][MAG_W-1:0];
        coefVal = coefMat[o][i][COEF_W-1] ? -$signed({1'b0, coefMag})
                                          :  $signed({1'b0, coefMag});
        prodC[o][i] = $signed({1'b0, pixIn[i]}) * coefVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int o = 0; o < 3; o++)
        for (int i = 0; i < 3; i++)
          prodQ[o][i] <= '0;
      bypQ1 <= '0;
    end else if (strobe.ld1) begin
      for (int o = 0; o < 3; o++)
        for (int i = 0; i < 3; i++)
          prodQ[o][i] <= prodC[o][i];
      bypQ1 <= pixIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bypQ2 <= '0;
    else if (strobe.ld2) bypQ2 <= bypQ1;
  end

  logic [2:0][DATA_W-1:0] laneOut;

  // stages 2 and 3, one lane per result
  for (genvar o = 0; o < 3; o++) begin : gLane
    localparam int SRC = (o == 0) ? 1 : ((o == 1) ? 2 : 0);
    localparam logic signed [SUM_W-1:0] HALF  = SUM_W'(1 << (FRAC_W - 1));
    localparam logic signed [RES_W-1:0] MAX_S = RES_W'(MAX_CODE);

    logic signed [SUM_W-1:0]  sumC, biasedC;
    logic signed [RND_W-1:0]  rndC;
    logic signed [OFS_W-1:0]  ofsC;
    logic signed [RES_W-1:0]  resC, accQ;
    logic [DATA_W-1:0]        satC, nextC, outReg;

    assign sumC    = SUM_W'(prodQ[o][0]) + SUM_W'(prodQ[o][1]) + SUM_W'(prodQ[o][2]);
    assign biasedC = sumC + HALF;
    assign rndC    = biasedC[SUM_W-1:FRAC_W];
    assign ofsC    = offsetVec[o][OFS_W-1] ? -$signed({1'b0, offsetVec[o][OFS_W-2:0]})
                                           :  $signed({1'b0, offsetVec[o][OFS_W-2:0]});
    assign resC    = RES_W'(rndC) + RES_W'(ofsC);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           accQ <= '0;
      else if (strobe.ld2) accQ <= resC;
    end

    always_comb begin
      if (accQ[RES_W-1])     satC = '0;
      else if (accQ > MAX_S) satC = DATA_W'(MAX_CODE);
      else                   satC = accQ[DATA_W-1:0];
    end

    always_comb begin
      if (strobe.byp3)        nextC = bypQ2[SRC];
      else if (strobe.clamp3) nextC = satC;
      else                    nextC = accQ[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           outReg <= '0;
      else if (strobe.ld3) outReg <= nextC;
    end

    assign laneOut[o] = outReg;
  end

  assign outGy  = laneOut[0];
  assign outBcb = laneOut[1];
  assign outRcr = laneOut[2];

endmodule

// File: rtl/color_matrix_csc.sv
module color_matrix_csc
  import csc_pkg::*;
#(
  parameter int DATA_W = CSC_DATA_W,
  parameter int INT_W  = CSC_INT_W,
  parameter int FRAC_W = CSC_FRAC_W,
  parameter int OFS_W  = CSC_OFS_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic [DATA_W-1:0]                 inR,
  input  logic [DATA_W-1:0]                 inG,
  input  logic [DATA_W-1:0]                 inB,
  input  logic [2:0][2:0][INT_W+FRAC_W-1:0] coefMat,
  input  logic [2:0][OFS_W-1:0]             offsetVec,
  input  logic                              bypassEn,
  input  logic                              clampEn,
  output logic                              outValid,
  output logic [DATA_W-1:0]                 outGy,
  output logic [DATA_W-1:0]                 outBcb,
  output logic [DATA_W-1:0]                 outRcr
);

  cscStrobe_t strobe;

  csc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .bypassEn (bypassEn),
    .clampEn  (clampEn),
    .strobe   (strobe),
    .outValid (outValid)
  );

  csc_datapath #(
    .DATA_W (DATA_W),
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W),
    .OFS_W  (OFS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inR       (inR),
    .inG       (inG),
    .inB       (inB),
    .coefMat   (coefMat),
    .offsetVec (offsetVec),
    .outGy     (outGy),
    .outBcb    (outBcb),
    .outRcr    (outRcr)
  );

endmodule

// File: rtl/csc_checker.sv
module csc_checker
  import csc_pkg::*;
#(
  parameter int DATA_W = CSC_DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inR,
  input logic [DATA_W-1:0] inG,
  input logic [DATA_W-1:0] inB,
  input logic              bypassEn,
  input cscStrobe_t        strobe,
  input logic              outValid,
  input logic [DATA_W-1:0] outGy,
  input logic [DATA_W-1:0] outBcb,
  input logic [DATA_W-1:0] outRcr
);

  logic [1:0] sinceRst;
  logic [2:0] bypRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      bypRun   <= '0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      if (!bypassEn)             bypRun <= '0;
      else if (bypRun != 3'd7)   bypRun <= bypRun + 3'd1;
    end
  end

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R8
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ld3 |=> outValid);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst != 2'd0) && !outValid) |->
      ($stable(outGy) && $stable(outBcb) && $stable(outRcr)));

  // R5
  bypass_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst == 2'd3) && (bypRun >= 3'd4) && outValid) |->
      ((outGy == $past(inG, 3)) && (outBcb == $past(inB, 3)) && (outRcr == $past(inR, 3))));

endmodule

bind color_matrix_csc csc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inR      (inR),
  .inG      (inG),
  .inB      (inB),
  .bypassEn (bypassEn),
  .strobe   (strobe),
  .outValid (outValid),
  .outGy    (outGy),
  .outBcb   (outBcb),
  .outRcr   (outRcr)
);

// File: tb/color_matrix_csc_bench.sv
`timescale 1ns/1ps
module color_matrix_csc_bench;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 inValid;
  logic [9:0]           inR, inG, inB;
  logic [2:0][2:0][15:0] coefMat;
  logic [2:0][9:0]      offsetVec;
  logic                 bypassEn, clampEn;
  logic                 outValid;
  logic [9:0]           outGy, outBcb, outRcr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  color_matrix_csc u_color_matrix_csc (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inR(inR), .inG(inG), .inB(inB),
    .coefMat(coefMat), .offsetVec(offsetVec),
    .bypassEn(bypassEn), .clampEn(clampEn),
    .outValid(outValid), .outGy(outGy), .outBcb(outBcb), .outRcr(outRcr)
  );

  // {R, G, B, expGy, expBcb, expRcr}, saturation on
  localparam logic [59:0] VEC [8] = '{
    {10'd0,    10'd0,    10'd0,    10'd10,   10'd0,    10'd0},
    {10'd100,  10'd200,  10'd300,  10'd260,  10'd230,  10'd0},
    {10'd1,    10'd3,    10'd1,    10'd14,   10'd0,    10'd1},
    {10'd3,    10'd0,    10'd0,    10'd12,   10'd0,    10'd5},
    {10'd1023, 10'd1023, 10'd0,    10'd1023, 10'd0,    10'd1023},
    {10'd0,    10'd0,    10'd1023, 10'd10,   10'd1003, 10'd0},
    {10'd600,  10'd100,  10'd900,  10'd410,  10'd855,  10'd450},
    {10'd5,    10'd0,    10'd3,    10'd13,   10'd0,    10'd6}
  };
  localparam string VTAG [8] = '{"R3", "R11", "R2", "R2", "R6", "R6", "R1", "R4"};

  // saturation off: v4, v5, v0
  localparam logic [59:0] WRAP [3] = '{
    {10'd1023, 10'd1023, 10'd0,    10'd521,  10'd748,  10'd511},
    {10'd0,    10'd0,    10'd1023, 10'd10,   10'd1003, 10'd513},
    {10'd0,    10'd0,    10'd0,    10'd10,   10'd1004, 10'd0}
  };

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expectPix(string tag, int gy, int bcb, int rcr);
    checkVal(tag, "outValid", int'(outValid), 1);
    checkVal(tag, "outGy",    int'(outGy),    gy);
    checkVal(tag, "outBcb",   int'(outBcb),   bcb);
    checkVal(tag, "outRcr",   int'(outRcr),   rcr);
  endtask

  task automatic drivePix(logic [9:0] r, logic [9:0] g, logic [9:0] b);
    inValid = 1'b1;
    inR = r; inG = g; inB = b;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inR = '0; inG = '0; inB = '0;
    bypassEn = 1'b0; clampEn = 1'b1;
    // [result][input]: result 0 GY,1 BCB,2 RCR; input 0 R,1 G,2 B
    coefMat[0][0] = 16'h0200; coefMat[0][1] = 16'h0400; coefMat[0][2] = 16'h0000;
    coefMat[1][0] = 16'h0000; coefMat[1][1] = 16'h8100; coefMat[1][2] = 16'h0400;
    coefMat[2][0] = 16'h0600; coefMat[2][1] = 16'h8000; coefMat[2][2] = 16'h8200;
    offsetVec[0] = 10'h00A; offsetVec[1] = 10'h214; offsetVec[2] = 10'h200;

    repeat (3) @(negedge clk);
    // R9 reset state
    checkVal("R9", "reset outValid", int'(outValid), 0);
    checkVal("R9", "reset outGy",    int'(outGy),    0);
    checkVal("R9", "reset outBcb",   int'(outBcb),   0);
    checkVal("R9", "reset outRcr",   int'(outRcr),   0);

    // R10: first pixel after reset uses the reset mode (bypass)
    @(negedge clk);
    rstN = 1'b1;
    drivePix(10'd7, 10'd500, 10'd1023);
    @(negedge clk);
    drivePix(10'd100, 10'd200, 10'd300);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    expectPix("R10", 500, 1023, 7);
    @(negedge clk);
    expectPix("R10", 260, 230, 0);

    // table streamed back to back, saturation on
    for (int j = 0; j < 11; j++) begin
      @(negedge clk);
      if (j >= 3) expectPix(VTAG[j-3], int'(VEC[j-3][29:20]), int'(VEC[j-3][19:10]), int'(VEC[j-3][9:0]));
      if (j < 8) drivePix(VEC[j][59:50], VEC[j][49:40], VEC[j][39:30]);
      else inValid = 1'b0;
    end

    // R8 latency of a lone pixel
    @(negedge clk);
    drivePix(10'd600, 10'd100, 10'd900);
    @(negedge clk);
    inValid = 1'b0;
    checkVal("R8", "outValid after one edge", int'(outValid), 0);
    @(negedge clk);
    checkVal("R8", "outValid after two edges", int'(outValid), 0);
    @(negedge clk);
    expectPix("R8", 410, 855, 450);

    // R9 hold and ignored inputs while inValid is low
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      inR = 10'd999 - 10'(k); inG = 10'd77; inB = 10'd512;
    end
    @(negedge clk);
    checkVal("R9", "idle outValid", int'(outValid), 0);
    checkVal("R9", "held outGy",    int'(outGy),    410);
    checkVal("R9", "held outBcb",   int'(outBcb),   855);
    checkVal("R9", "held outRcr",   int'(outRcr),   450);
    drivePix(10'd3, 10'd0, 10'd0);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expectPix("R9", 12, 0, 5);

    // R7 wrap with saturation off
    clampEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (j >= 3) expectPix("R7", int'(WRAP[j-3][29:20]), int'(WRAP[j-3][19:10]), int'(WRAP[j-3][9:0]));
      if (j < 3) drivePix(WRAP[j][59:50], WRAP[j][49:40], WRAP[j][39:30]);
      else inValid = 1'b0;
    end

    // R5 bypass routing
    bypassEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    drivePix(10'd7, 10'd500, 10'd1023);
    @(negedge clk);
    drivePix(10'd1023, 10'd0, 10'd512);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    expectPix("R5", 500, 1023, 7);
    @(negedge clk);
    expectPix("R5", 0, 512, 1023);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule